// File: doc/BRIEF.md
# Read-Once Secret Word Store

This core holds a 256-bit device secret and lets the CPU bus read it as eight 32-bit words. The secret never leaves the core through any path other than the read data port, and each word can leave it only once per reset. Firmware reads the words it needs while the mode input shows that trusted firmware is in control. Any later read of a consumed word, or any read made after control has passed to application code, returns zero.

The secret is a fixed module parameter. It is held as one small table per output bit. Each table is addressed by the word index plus that word's sticky "spent" flag, and the half of the table selected by a set flag contains only zeros. A control module decodes the bus and keeps the flags. A datapath module holds the tables and the output register. A thin top module joins the two.

Top module: `once_secret_store`

## Requirements
- R1: Word i (0 to 7) sits at byte address 0x10+i. A first valid read returns bits [32i+31:32i] of the SECRET parameter.
- R2: Reads are registered. When chip select is high at a clock edge, ready is high for the following cycle and read data is valid in that cycle. Ready is low in any cycle that follows an edge with chip select low.
- R3: A read at an address outside 0x10..0x17 returns zero and marks no word as read.
- R4: While the application-mode input is high, reads return zero and mark no word as read.
- R5: Each word has its own read flag, cleared by reset. Words may be read in any order. Every read of a word after its first valid read returns zero until the next reset.
- R6: If chip select stays high on one word, the first cycle after the access returns the word and every later cycle returns zero.
- R7: An access with write enable high changes no stored state, returns zero and marks no word as read.
- R8: When no valid read took place at the previous edge, read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| appMode | input | 1 | High when application code runs; blocks secret reads |
| cs | input | 1 | Bus chip select |
| we | input | 1 | Bus write enable (writes are ignored) |
| addr | input | 8 | Bus word address |
| rdData | output | 32 | Registered read data |
| ready | output | 1 | Access acknowledge, one cycle after chip select |

## Verification
A flag that is wrongly set shows as a zero word one cycle after the first read of that word. A flag that is wrongly left clear shows as the secret coming back a second time, on the next read of that word or on the cycle after a held chip select. A flag set by a blocked or ignored access stays hidden until the next legal read of that word, so every blocked or ignored access is followed by a legal read of the same word. Flags are cleared only by reset, so a reset followed by a repeated read shows whether reset clears them.

// File: rtl/oss_pkg.sv
package oss_pkg;

  // Width of the word index carried from control to datapath
  localparam int OSS_IDX_W = 3;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic                 load;   // capture table output this edge
    logic                 spent;  // read flag of the addressed word
    logic [OSS_IDX_W-1:0] idx;    // word index
  } ossStrobe_t;

endpackage

// File: rtl/oss_ctrl.sv
module oss_ctrl
  import oss_pkg::*;
#(
  parameter int               WORDS     = 8,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              appMode,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output ossStrobe_t        strb,
  output logic              ready
);

  localparam int IDX_W = OSS_IDX_W;

  logic [ADDR_W-1:0] offset;
  logic              inRange;
  logic              validRd;
  logic [IDX_W-1:0]  wordIdx;
  logic [WORDS-1:0]  readFlags;

  always_comb begin
    offset  = addr - BASE_ADDR;
    inRange = offset < ADDR_W'(WORDS);
    wordIdx = offset[IDX_W-1:0];
    validRd = cs && !we && !appMode && inRange;
    strb.load  = validRd;
    strb.spent = readFlags[wordIdx];
    strb.idx   = wordIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readFlags <= '0;
      ready     <= 1'b0;
    end else begin
      ready <= cs;
      if (validRd) readFlags[wordIdx] <= 1'b1;
    end
  end

  // R4
  mode_blocks_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    appMode |=> $stable(readFlags));

  // R7
  write_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we) |=> $stable(readFlags));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(readFlags) & ~readFlags) == '0) &&
             ($countones(readFlags ^ $past(readFlags)) <= 1));

endmodule

// File: rtl/oss_datapath.sv
module oss_datapath
  import oss_pkg::*;
#(
  parameter int                      WORDS  = 8,
  parameter int                      WORD_W = 32,
  parameter logic [WORDS*WORD_W-1:0] SECRET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ossStrobe_t        strb,
  output logic [WORD_W-1:0] rdData
);

  localparam int TBL_D = 2 ** (OSS_IDX_W + 1);

  // Table for one output bit: lower half holds the secret bit of each
  // word, upper half (selected by a set read flag) holds zeros.
  function automatic logic [TBL_D-1:0] mkTable(input int bitPos);
    logic [TBL_D-1:0] t;
    t = '0;
    for (int i = 0; i < WORDS; i++) t[i] = SECRET[i*WORD_W + bitPos];
    return t;
  endfunction

  logic [OSS_IDX_W:0] tblAddr;
  logic [WORD_W-1:0]  tblOut;

  assign tblAddr = {strb.spent, strb.idx};

  for (genvar j = 0; j < WORD_W; j++) begin : g_bitTable
    localparam logic [TBL_D-1:0] TBL = mkTable(j);
    assign tblOut[j] = TBL[tblAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.load ? tblOut : '0;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> rdData == '0);

  // R6
  spent_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.spent) |=> rdData == '0);

endmodule

// File: rtl/once_secret_store.sv
module once_secret_store
  import oss_pkg::*;
#(
  parameter int                      WORDS     = 8,
  parameter int                      WORD_W    = 32,
  parameter int                      ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]       BASE_ADDR = 8'h10,
  parameter logic [WORDS*WORD_W-1:0] SECRET    = {
    32'hF0E1D2C3, 32'h0F1E2D3C, 32'h2468ACE0, 32'h13579BDF,
    32'hCAFEF00D, 32'hDEADBEEF, 32'h89ABCDEF, 32'h01234567}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              appMode,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rdData,
  output logic              ready
);

  ossStrobe_t strb;

  oss_ctrl #(
    .WORDS(WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .appMode(appMode), .cs(cs), .we(we),
    .addr(addr), .strb(strb), .ready(ready)
  );

  oss_datapath #(
    .WORDS(WORDS), .WORD_W(WORD_W), .SECRET(SECRET)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData)
  );

endmodule

// File: tb/test_once_secret_store.sv
module test_once_secret_store;

  localparam int CLK_P = 10;
  localparam int NVEC  = 10;

  // Expected secret words (R1)
  localparam logic [31:0] W0 = 32'h01234567, W1 = 32'h89ABCDEF,
                          W2 = 32'hDEADBEEF, W3 = 32'hCAFEF00D,
                          W4 = 32'h13579BDF, W5 = 32'h2468ACE0,
                          W6 = 32'h0F1E2D3C, W7 = 32'hF0E1D2C3;

  // vector: {addr[7:0], we, appMode, expected[31:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h13, 1'b0, 1'b0, W3},     // R1 first read
    {8'h13, 1'b0, 1'b0, 32'h0},  // R5 second read zero
    {8'h10, 1'b0, 1'b1, 32'h0},  // R4 app mode blocks
    {8'h10, 1'b0, 1'b0, W0},     // R4 no flag was set
    {8'h11, 1'b1, 1'b0, 32'h0},  // R7 write ignored
    {8'h11, 1'b0, 1'b0, W1},     // R7 no flag was set
    {8'h18, 1'b0, 1'b0, 32'h0},  // R3 above range
    {8'h0F, 1'b0, 1'b0, 32'h0},  // R3 below range
    {8'h17, 1'b0, 1'b0, W7},     // R5 any order
    {8'h15, 1'b0, 1'b0, W5}      // R5 any order
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        appMode = 1'b0, cs = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] rdData;
  logic        ready;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  once_secret_store i_once_secret_store (
    .clk(clk), .rstN(rstN), .appMode(appMode), .cs(cs), .we(we),
    .addr(addr), .rdData(rdData), .ready(ready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Single access: drive at negedge, sample at the next negedge
  task automatic access(input logic [7:0] a, input logic w, input logic m,
                        output logic [31:0] d, output logic r);
    @(negedge clk);
    cs = 1'b1; we = w; appMode = m; addr = a;
    @(negedge clk);
    d = rdData; r = ready;
    cs = 1'b0; we = 1'b0; appMode = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic [31:0] d;
    logic        r;
    repeat (2) @(negedge clk);
    // R2 / R8 reset state
    check("R8 reset data", rdData, 32'h0);
    check("R2 reset ready", {31'h0, ready}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle ready", {31'h0, ready}, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      access(VEC[k][41:34], VEC[k][33], VEC[k][32], d, r);
      check($sformatf("R1/R3/R4/R5/R7 vec %0d", k), d, VEC[k][31:0]);
      check($sformatf("R2 ready vec %0d", k), {31'h0, r}, 32'h1);
    end

    // R8 / R2 after access ends
    @(negedge clk);
    check("R8 idle data", rdData, 32'h0);
    check("R2 idle ready after access", {31'h0, ready}, 32'h0);

    // R1 remaining words
    access(8'h12, 1'b0, 1'b0, d, r); check("R1 word2", d, W2);
    access(8'h14, 1'b0, 1'b0, d, r); check("R1 word4", d, W4);

    // R5 reset clears flags
    doReset();
    access(8'h13, 1'b0, 1'b0, d, r); check("R5 after reset", d, W3);

    // R6 held chip select
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 8'h16;
    @(negedge clk);
    check("R6 held first", rdData, W6);
    @(negedge clk);
    check("R6 held second", rdData, 32'h0);
    check("R2 held ready", {31'h0, ready}, 32'h1);
    @(negedge clk);
    check("R6 held third", rdData, 32'h0);
    cs = 1'b0;
    @(negedge clk);
    check("R8 after hold", rdData, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule